// File: doc/BRIEF.md
# Prioritized Locality Arbiter

This block decides which of five localities owns a shared register interface. Software in each locality writes a small per-locality control byte to ask for ownership, give it up, take it by force, or clear a flag. Every write carries an address, and the locality is taken from address bits [14:12]. The block keeps one owner at most. It publishes the owner on `active_loc`, using 0xFF when there is no owner, and raises `loc_changed` for one cycle whenever the owner value changes.

A command engine outside the block reports through `cmd_busy` that a command is executing. If a handover is requested while a command runs, the handover is held back. The block pulses `cmd_cancel` and completes the switch when the engine pulses `cmd_done`. Reads are combinational: `rd_data` shows the control byte of the locality addressed by `rd_addr`.

No data stream passes through this block. All pins are plain control and status signals with no valid/ready handshake and no back-pressure: a write takes effect on the clock edge where `wr_en` is high, and the outputs it causes appear on the next edge.

Top module: `loc_arbiter`

## Requirements
- R1: After reset, `active_loc` is 0xFF, no flags are set for any locality, and `loc_changed` and `cmd_cancel` are low.
- R2: A write with bit1 (request) set, from a locality that does not own the interface, makes that locality the owner at once if there is no owner. If another locality owns the interface, it sets the writer's request flag instead, which reads back as bit1.
- R3: A write with bit0 (active) set from the owner releases ownership. The new owner is the highest-numbered locality with its request flag set, or nobody (0xFF) if no locality is requesting.
- R4: A write with bit0 set from a locality that is not the owner clears that locality's request flag.
- R5: A write with bit2 (seize) set is accepted only if there is no owner or the writer is numbered higher than the owner. It is ignored if the writer already has a seize pending, or if a higher locality has one. When accepted, it drops the seize requests of all lower localities. The seize bit has priority over the request and active bits of the same write.
- R6: When ownership is taken by a seize, the old owner loses active and gets bit3 (been-seized) set. When ownership passes in any other way, the old owner loses both active and request.
- R7: The new owner reads bit0 set, and its request and seize flags are cleared. A request write from the owner has no effect.
- R8: A read returns bit0 active, bit1 request, bit3 been-seized, and bit4 pending. Pending is high when any other locality has its request flag set. Bit2 (seize) always reads 0. Reads of localities 5 to 7 return 0.
- R9: If `cmd_busy` is high when a handover is requested, the owner does not change, and `cmd_cancel` pulses in the next cycle. The deferred switch takes place on the cycle `cmd_done` is high.
- R10: Writes addressed to locality 4, or to localities 5 to 7, change nothing.
- R11: A write with bit3 set clears the writer's been-seized flag.
- R12: `loc_changed` is high for exactly the cycles in which `active_loc` has just taken a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 15 | Write address; bits [14:12] select the locality |
| wr_data | input | 8 | Control byte written |
| rd_addr | input | 15 | Read address; bits [14:12] select the locality |
| rd_data | output | 8 | Control byte of the addressed locality |
| cmd_busy | input | 1 | A command is executing |
| cmd_done | input | 1 | One-cycle pulse: the executing command finished |
| cmd_cancel | output | 1 | One-cycle pulse asking the engine to cancel its command |
| active_loc | output | 8 | Owning locality, 0xFF if none |
| loc_changed | output | 1 | One-cycle pulse when `active_loc` changes |

## Verification
The assertions assume that `cmd_done` is a single-cycle pulse and that `cmd_cancel` is only produced while `cmd_busy` was high the cycle before. The stability checks on ignored writes and on deferred handovers also assume that no completion arrives in the same cycle. The stimulus therefore changes `cmd_busy` only between writes, pulses `cmd_done` on a cycle with no write, and drops `cmd_busy` together with that pulse. The bench checks the effect of each write one cycle later, at the outputs and through the read port.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int CTRL_W     = 8;
  localparam int B_ACTIVE   = 0;
  localparam int B_REQ      = 1;
  localparam int B_SEIZE    = 2;
  localparam int B_SEIZED   = 3;
  localparam int B_PEND     = 4;
  localparam logic [CTRL_W-1:0] NO_OWNER = 8'hFF;
endpackage

// File: rtl/loc_arb_addr_dec.sv
module loc_arb_addr_dec #(
  parameter int ADDR_W  = 15,
  parameter int LOC_LSB = 12,
  parameter int LOC_W   = 3,
  parameter int NUM_LOC = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOC_W-1:0]  loc,
  output logic              in_range,
  output logic              writable
);
  localparam logic [LOC_W-1:0] LAST = LOC_W'(NUM_LOC - 1);

  logic unused_low;
  assign unused_low = ^addr[LOC_LSB-1:0];

  assign loc      = addr[LOC_LSB +: LOC_W];
  assign in_range = (loc <= LAST);
  // the top locality is read-only
  assign writable = (loc < LAST);
endmodule

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic [NUM_LOC-1:0] req,
  output logic               found,
  output logic [LOC_W-1:0]   idx
);
  // later iterations overwrite earlier ones: highest set index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = i[LOC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/loc_arb_view.sv
module loc_arb_view
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic [LOC_W-1:0]   loc,
  input  logic               in_range,
  input  logic               own_vld,
  input  logic [LOC_W-1:0]   own,
  input  logic [NUM_LOC-1:0] req,
  input  logic [NUM_LOC-1:0] seized,
  output logic [CTRL_W-1:0]  rd_data
);
  localparam logic [NUM_LOC-1:0] ONE = NUM_LOC'(1);

  logic [NUM_LOC-1:0] pend_v;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_pend
    assign pend_v[g] = |(req & ~(ONE << g));
  end

  always_comb begin
    rd_data = '0;
    if (in_range) begin
      rd_data[B_ACTIVE] = own_vld && (own == loc);
      rd_data[B_REQ]    = req[loc];
      rd_data[B_SEIZED] = seized[loc];
      rd_data[B_PEND]   = pend_v[loc];
    end
  end
endmodule

// File: rtl/loc_arb_core.sv
module loc_arb_core
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [LOC_W-1:0]   wr_loc,
  input  logic               wr_ok,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic               cmd_busy,
  input  logic               cmd_done,
  output logic               own_vld,
  output logic [LOC_W-1:0]   own,
  output logic [NUM_LOC-1:0] req,
  output logic [NUM_LOC-1:0] seized,
  output logic               cmd_cancel,
  output logic               loc_changed
);
  typedef struct packed {
    logic [NUM_LOC-1:0] req;
    logic [NUM_LOC-1:0] sz;
    logic [NUM_LOC-1:0] bs;
    logic               ov;
    logic [LOC_W-1:0]   own;
  } st_t;

  st_t              st_q, st_mid, st_d;
  logic             pv_q, pv_mid, pv_d;
  logic [LOC_W-1:0] pl_q, pl_d;
  logic             cancel_d, chg_d;
  logic             pick_found;
  logic [LOC_W-1:0] pick_idx;

  // move ownership to (tv,tl), updating old and new owner flags
  function automatic st_t f_switch(st_t s, logic tv, logic [LOC_W-1:0] tl);
    st_t  r;
    logic chg;
    r   = s;
    chg = (s.ov != tv) || (tv && (s.own != tl));
    if (chg && s.ov) begin
      if (tv && s.sz[tl]) r.bs[s.own] = 1'b1;
      else                r.req[s.own] = 1'b0;
    end
    r.ov = tv;
    if (tv) begin
      r.own     = tl;
      r.req[tl] = 1'b0;
      r.sz[tl]  = 1'b0;
    end
    return r;
  endfunction

  // stage 1: complete a deferred handover
  always_comb begin
    st_mid = st_q;
    pv_mid = pv_q;
    if (cmd_done && pv_q) begin
      st_mid = f_switch(st_q, 1'b1, pl_q);
      pv_mid = 1'b0;
    end
  end

  loc_arb_pick #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_pick (
    .req   (st_mid.req),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // stage 2: apply a register write
  always_comb begin
    st_t              s;
    logic [CTRL_W-1:0] v;
    logic             tv, setnew, ab_go, mine, higher;
    logic [LOC_W-1:0] tl, ab_loc;
    s        = st_mid;
    pv_d     = pv_mid;
    pl_d     = pl_q;
    cancel_d = 1'b0;
    v        = wr_data;
    tv       = s.ov;
    tl       = s.own;
    setnew   = 1'b1;
    ab_go    = 1'b0;
    ab_loc   = '0;
    higher   = 1'b0;
    mine     = s.ov && (s.own == wr_loc);
    if (wr_en && wr_ok) begin
      if (v[B_SEIZE]) begin
        v[B_REQ]    = 1'b0;
        v[B_ACTIVE] = 1'b0;
      end
      if (v[B_ACTIVE]) begin
        if (mine) begin
          if (pick_found) begin
            setnew = 1'b0;
            ab_go  = 1'b1;
            ab_loc = pick_idx;
          end else begin
            tv = 1'b0;
          end
        end else begin
          s.req[wr_loc] = 1'b0;
        end
      end
      if (v[B_SEIZED]) s.bs[wr_loc] = 1'b0;
      if (v[B_SEIZE] && (!s.ov || (wr_loc > s.own))) begin
        for (int i = 0; i < NUM_LOC; i++)
          if ((i > int'(wr_loc)) && s.sz[i]) higher = 1'b1;
        if (!s.sz[wr_loc] && !higher) begin
          for (int i = 0; i < NUM_LOC; i++)
            if (i < int'(wr_loc)) s.sz[i] = 1'b0;
          s.sz[wr_loc] = 1'b1;
          setnew = 1'b0;
          ab_go  = 1'b1;
          ab_loc = wr_loc;
        end
      end
      if (v[B_REQ] && !mine) begin
        if (s.ov) s.req[wr_loc] = 1'b1;
        else begin
          tv = 1'b1;
          tl = wr_loc;
        end
      end
      if (setnew) s = f_switch(s, tv, tl);
      if (ab_go) begin
        if (cmd_busy) begin
          pv_d     = 1'b1;
          pl_d     = ab_loc;
          cancel_d = 1'b1;
        end else begin
          s    = f_switch(s, 1'b1, ab_loc);
          pv_d = 1'b0;
        end
      end
    end
    st_d  = s;
    chg_d = (st_d.ov != st_q.ov) || (st_d.ov && (st_d.own != st_q.own));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= '0;
      pv_q        <= 1'b0;
      pl_q        <= '0;
      cmd_cancel  <= 1'b0;
      loc_changed <= 1'b0;
    end else begin
      st_q        <= st_d;
      pv_q        <= pv_d;
      pl_q        <= pl_d;
      cmd_cancel  <= cancel_d;
      loc_changed <= chg_d;
    end
  end

  assign own_vld = st_q.ov;
  assign own     = st_q.own;
  assign req     = st_q.req;
  assign seized  = st_q.bs;

  // R5: at most one seize is ever pending
  p_seize_single_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_q.sz));

  // R7: the owner never keeps a request flag
  p_owner_no_req_r7: assert property (@(posedge clk) disable iff (rst)
    st_q.ov |-> !st_q.req[st_q.own]);

  // R10: writes to the read-only or absent localities leave state alone
  p_locked_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ok && !cmd_done) |=> ($stable(st_q) && !loc_changed));

  // R9: a deferred handover keeps the owner until completion
  p_defer_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pv_q && !cmd_done && !wr_en) |=> ($stable(st_q.ov) && $stable(st_q.own)));

  // R9: cancel is only raised for a busy engine
  p_cancel_busy_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_cancel |-> $past(cmd_busy));

  // R12: every owner change is flagged
  p_change_flag_r12: assert property (@(posedge clk) disable iff (rst)
    ((st_q.ov != $past(st_q.ov)) || (st_q.ov && (st_q.own != $past(st_q.own))))
      |-> loc_changed);
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int LOC_LSB = 12,
  parameter int LOC_W   = 3,
  parameter int NUM_LOC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              cmd_busy,
  input  logic              cmd_done,
  output logic              cmd_cancel,
  output logic [7:0]        active_loc,
  output logic              loc_changed
);
  logic [LOC_W-1:0]   w_loc, r_loc, own;
  logic               w_ok, w_in, r_in, r_ok, own_vld;
  logic [NUM_LOC-1:0] req, seized;
  logic               unused_flags;

  assign unused_flags = w_in ^ r_ok;

  loc_arb_addr_dec #(.ADDR_W(ADDR_W), .LOC_LSB(LOC_LSB), .LOC_W(LOC_W),
                     .NUM_LOC(NUM_LOC)) u_wdec (
    .addr(wr_addr), .loc(w_loc), .in_range(w_in), .writable(w_ok));

  loc_arb_addr_dec #(.ADDR_W(ADDR_W), .LOC_LSB(LOC_LSB), .LOC_W(LOC_W),
                     .NUM_LOC(NUM_LOC)) u_rdec (
    .addr(rd_addr), .loc(r_loc), .in_range(r_in), .writable(r_ok));

  loc_arb_core #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_loc(w_loc), .wr_ok(w_ok),
    .wr_data(wr_data), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
    .own_vld(own_vld), .own(own), .req(req), .seized(seized),
    .cmd_cancel(cmd_cancel), .loc_changed(loc_changed));

  loc_arb_view #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_view (
    .loc(r_loc), .in_range(r_in), .own_vld(own_vld), .own(own),
    .req(req), .seized(seized), .rd_data(rd_data));

  assign active_loc = own_vld ? {{(CTRL_W-LOC_W){1'b0}}, own} : NO_OWNER;

  // R8: the seize flag is never visible on a read
  p_seize_hidden_r8: assert property (@(posedge clk) disable iff (rst)
    rd_data[B_SEIZE] == 1'b0);

  // R1: no owner and no event directly after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (active_loc == NO_OWNER) && !loc_changed && !cmd_cancel);
endmodule

// File: tb/loc_arbiter_tb.sv
module loc_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        cmd_busy = 1'b0;
  logic        cmd_done = 1'b0;
  logic        cmd_cancel;
  logic [7:0]  active_loc;
  logic        loc_changed;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] act;
    logic       chg;
    logic       cxl;
    logic [7:0] rd;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  loc_arbiter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmd_busy(cmd_busy),
    .cmd_done(cmd_done), .cmd_cancel(cmd_cancel), .active_loc(active_loc),
    .loc_changed(loc_changed));

  // monitor: compares outputs against queued expectations
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      #1;
      e = q.pop_front();
      checks++;
      if (active_loc !== e.act || loc_changed !== e.chg ||
          cmd_cancel !== e.cxl || rd_data !== e.rd) begin
        errors++;
        $display("FAIL %s: act=%h chg=%b cxl=%b rd=%h expected act=%h chg=%b cxl=%b rd=%h",
                 e.tag, active_loc, loc_changed, cmd_cancel, rd_data,
                 e.act, e.chg, e.cxl, e.rd);
      end
    end
  end

  task automatic wr(input int loc, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 15'(loc << 12) | 15'h0014;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    cmd_done = 1'b1;
    cmd_busy = 1'b0;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic expect_st(input string tag, input logic [7:0] act, input logic chg,
                           input logic cxl, input int rloc, input logic [7:0] rd);
    exp_t e;
    rd_addr = 15'(rloc << 12);
    e.tag = tag; e.act = act; e.chg = chg; e.cxl = cxl; e.rd = rd;
    q.push_back(e);
    wait (q.size() == 0);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: act=%h expected run to end", active_loc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_st("R1 reset", 8'hFF, 0, 0, 0, 8'h00);

    wr(1, 8'h02);
    expect_st("R2 grant when free", 8'h01, 1, 0, 1, 8'h01);
    wr(0, 8'h02);
    expect_st("R2 request while owned", 8'h01, 0, 0, 0, 8'h02);
    expect_st("R8 pending seen by owner", 8'h01, 0, 0, 1, 8'h11);
    wr(2, 8'h02);
    expect_st("R8 pending for requester", 8'h01, 0, 0, 2, 8'h12);

    wr(1, 8'h01);
    expect_st("R3 release to highest", 8'h02, 1, 0, 2, 8'h11);
    expect_st("R6 normal switch clears old", 8'h02, 1, 0, 1, 8'h10);
    wr(0, 8'h01);
    expect_st("R4 non-owner drops request", 8'h02, 0, 0, 0, 8'h00);

    wr(3, 8'h04);
    expect_st("R5 R6 seize marks old owner", 8'h03, 1, 0, 2, 8'h08);
    expect_st("R7 R8 new owner flags", 8'h03, 1, 0, 3, 8'h01);
    wr(2, 8'h08);
    expect_st("R11 clear been-seized", 8'h03, 0, 0, 2, 8'h00);
    wr(1, 8'h04);
    expect_st("R5 lower seize ignored", 8'h03, 0, 0, 1, 8'h00);

    wr(4, 8'h02);
    expect_st("R10 locality 4 write ignored", 8'h03, 0, 0, 3, 8'h01);
    wr(6, 8'h02);
    expect_st("R10 locality 6 write ignored", 8'h03, 0, 0, 3, 8'h01);
    expect_st("R8 absent locality reads 0", 8'h03, 0, 0, 6, 8'h00);

    @(negedge clk); cmd_busy = 1'b1;
    wr(2, 8'h02);
    wr(3, 8'h01);
    expect_st("R9 release deferred", 8'h03, 0, 1, 3, 8'h11);
    done_pulse();
    expect_st("R9 switch on done", 8'h02, 1, 0, 3, 8'h00);

    @(negedge clk); cmd_busy = 1'b1;
    wr(3, 8'h04);
    expect_st("R9 R5 seize deferred", 8'h02, 0, 1, 2, 8'h01);
    wr(3, 8'h04);
    expect_st("R5 repeat seize ignored", 8'h02, 0, 0, 2, 8'h01);
    done_pulse();
    expect_st("R6 deferred seize marks old", 8'h03, 1, 0, 2, 8'h08);

    wr(2, 8'h08);
    wr(3, 8'h01);
    expect_st("R3 release to none", 8'hFF, 1, 0, 3, 8'h00);

    wr(0, 8'h02);
    expect_st("R2 grant locality 0", 8'h00, 1, 0, 0, 8'h01);
    @(negedge clk); cmd_busy = 1'b1;
    wr(3, 8'h04);
    expect_st("R9 seize by 3 deferred", 8'h00, 0, 1, 0, 8'h01);
    wr(1, 8'h04);
    expect_st("R5 blocked by higher seize", 8'h00, 0, 0, 1, 8'h00);
    done_pulse();
    expect_st("R6 seized owner 0", 8'h03, 1, 0, 0, 8'h08);

    wr(3, 8'h01);
    expect_st("R12 change to none", 8'hFF, 1, 0, 3, 8'h00);
    wr(2, 8'h04);
    expect_st("R5 seize with no owner", 8'h02, 1, 0, 2, 8'h01);
    expect_st("R6 no been-seized without owner", 8'h02, 1, 0, 3, 8'h00);
    wr(2, 8'h02);
    expect_st("R7 owner request no effect", 8'h02, 0, 0, 2, 8'h01);
    @(negedge clk);
    expect_st("R12 pulse lasts one cycle", 8'h02, 0, 0, 2, 8'h01);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule